// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer

This block sits between a microcontroller that shares its low address byte with its data byte and the memories behind it. It samples the shared byte lines, the upper address port, the active-high address strobe and the three active-low access strobes (data read, data write, program fetch) into a fast system clock. For each bus cycle it recovers a full address and the kind of access. Program fetches see a 16-bit space. Data accesses see a 24-bit space without bank switching. On a data cycle the upper port carries bits 23..16 while the address strobe is high and bits 15..8 after it falls, so both parts come from the same pins at different times.

The outputs are a 24-bit data-space address, a 16-bit program-space address, a two-bit cycle type, an access-active flag, the byte captured at the end of each write, a sticky error flag for overlapping strobes, and a registered read-data port with its own output-enable. When the internal-code option is on, fetches below 2000h belong to the controller's own code store and are not flagged as external.

Top module: `mbd_demux`

## Requirements
- R1: While reset is asserted, and in the cycle after it is applied, both addresses, the cycle type, the access flag, the error flag, the write byte, its valid pulse, the read byte and its output-enable are all zero.
- R2: A pin level sampled at rising edge n appears on the outputs after rising edge n+2. The low address byte and the upper-port value follow the pins while the address strobe is sampled high. They hold once it is sampled low. They form data address bits 7..0 and 23..16.
- R3: Data address bits 15..8 are the live upper-port value, with the same two-edge delay and no latching.
- R4: The program address is the live upper-port value above the latched low byte.
- R5: The cycle type is 1 when only the fetch strobe is low, 2 when only the read strobe is low, 3 when only the write strobe is low, and 0 when no strobe or more than one strobe is low.
- R6: The access flag is high whenever the cycle type is non-zero. The exception is that, with the internal-code option on, a fetch whose program address is below 2000h leaves it low.
- R7: When more than one strobe is sampled low, the error flag rises and stays high until reset.
- R8: When the write strobe is sampled rising, the byte on the shared lines at its last low sample goes to the write-data output. The valid output pulses for exactly one clock.
- R9: The read output-enable is high exactly when only the read strobe was sampled low. The read byte register loads the memory data on those cycles and holds otherwise. The enable drops one clock after the synchronised read strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad_i | input | 8 | Shared low address / data lines |
| bus_hi_i | input | 8 | Upper address port |
| ale_i | input | 1 | Address strobe, active high |
| rd_n_i | input | 1 | Data read strobe, active low |
| wr_n_i | input | 1 | Data write strobe, active low |
| psen_n_i | input | 1 | Program fetch strobe, active low |
| rdata_i | input | 8 | Read data from memory |
| data_addr_o | output | 24 | Recovered data-space address |
| prog_addr_o | output | 16 | Recovered program-space address |
| cyc_type_o | output | 2 | 0 none, 1 fetch, 2 read, 3 write |
| access_o | output | 1 | External access active |
| proto_err_o | output | 1 | Sticky overlapping-strobe error |
| wdata_o | output | 8 | Byte captured at write end |
| wdata_vld_o | output | 1 | One-clock pulse with a new write byte |
| rdout_o | output | 8 | Registered read byte |
| rdout_oe_o | output | 1 | Read byte output-enable |

## Verification
The properties assume that the address strobe, the upper port and the shared lines pass through the same synchroniser depth. They also assume that every pin holds each level for several system clocks, so that the last sample taken with the strobe high carries a settled address. The stimulus moves all pins only on falling clock edges and keeps each bus phase two to four clocks long. It keeps the upper port and low byte steady for two clocks after the address strobe falls, and keeps the write byte on the lines for two clocks after the write strobe rises. Overlapping strobes are driven on purpose only in one dedicated burst that exercises the error flag.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
   // Cycle type encoding; the values are visible on cyc_type_o.
   typedef enum logic [1:0] {
      CYC_NONE  = 2'd0,
      CYC_FETCH = 2'd1,
      CYC_READ  = 2'd2,
      CYC_WRITE = 2'd3
   } cyc_e;
endpackage

// File: rtl/mbd_sync.sv
// Multi-stage synchroniser for a bundle of bus pins; every bit shares one depth.
module mbd_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mbd_addr_latch.sv
// Clocked equivalent of a transparent address latch: follows while the strobe
// is high, holds once it is low. Also aligns the live upper port and shared byte.
module mbd_addr_latch #(
   parameter int AD_W = 8,
   parameter int HI_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ale_s,
   input  logic [AD_W-1:0]  ad_s,
   input  logic [HI_W-1:0]  hi_s,
   output logic [AD_W-1:0]  lat_lo_o,
   output logic [HI_W-1:0]  lat_hi_o,
   output logic [HI_W-1:0]  hi_q_o,
   output logic [AD_W-1:0]  ad_q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_lo_o <= '0;
         lat_hi_o <= '0;
      end else if (ale_s) begin
         lat_lo_o <= ad_s;
         lat_hi_o <= hi_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q_o <= '0;
         ad_q_o <= '0;
      end else begin
         hi_q_o <= hi_s;
         ad_q_o <= ad_s;
      end
   end
endmodule

// File: rtl/mbd_cycle_decode.sv
// Strobe decoding: cycle type, access flag, sticky overlap error, write capture.
module mbd_cycle_decode
   import mbd_pkg::*;
#(
   parameter int          AD_W         = 8,
   parameter int          PROG_AW      = 16,
   parameter bit          INT_CODE_EN  = 1'b1,
   parameter int unsigned INT_CODE_TOP = 32'h2000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               psen_n_s,
   input  logic               rd_n_s,
   input  logic               wr_n_s,
   input  logic [AD_W-1:0]    ad_q,
   input  logic [PROG_AW-1:0] prog_addr_i,
   output cyc_e               cyc_o,
   output logic               access_o,
   output logic               err_o,
   output logic [AD_W-1:0]    wdata_o,
   output logic               wvld_o,
   output logic               rd_only_o
);
   localparam logic [PROG_AW-1:0] TOP_L = PROG_AW'(INT_CODE_TOP);

   // bit 2 fetch, bit 1 read, bit 0 write; 1 = strobe active
   logic [2:0] low_s;
   logic [2:0] str_q;
   logic       multi_s;
   logic       internal;

   assign low_s     = {~psen_n_s, ~rd_n_s, ~wr_n_s};
   assign multi_s   = (low_s & (low_s - 3'd1)) != 3'd0;
   assign rd_only_o = (low_s == 3'b010);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         str_q   <= '0;
         err_o   <= 1'b0;
         wdata_o <= '0;
         wvld_o  <= 1'b0;
      end else begin
         str_q  <= low_s;
         err_o  <= err_o | multi_s;
         wvld_o <= 1'b0;
         if (str_q[0] && !low_s[0]) begin
            wdata_o <= ad_q;
            wvld_o  <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (str_q)
         3'b100:  cyc_o = CYC_FETCH;
         3'b010:  cyc_o = CYC_READ;
         3'b001:  cyc_o = CYC_WRITE;
         default: cyc_o = CYC_NONE;
      endcase
   end

   generate
      if (INT_CODE_EN) begin : g_int_code
         assign internal = (cyc_o == CYC_FETCH) && (prog_addr_i < TOP_L);
      end else begin : g_no_int_code
         assign internal = 1'b0;
      end
   endgenerate

   assign access_o = (cyc_o != CYC_NONE) && !internal;
endmodule

// File: rtl/mbd_read_port.sv
// Registered read byte with an enable tied to a sole, synchronised read strobe.
module mbd_read_port #(
   parameter int AD_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_only_s,
   input  logic [AD_W-1:0] rdata_i,
   output logic [AD_W-1:0] rdout_o,
   output logic            oe_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdout_o <= '0;
         oe_o    <= 1'b0;
      end else begin
         oe_o <= rd_only_s;
         if (rd_only_s) rdout_o <= rdata_i;
      end
   end
endmodule

// File: rtl/mbd_demux.sv
module mbd_demux
   import mbd_pkg::*;
#(
   parameter int          AD_W         = 8,
   parameter int          HI_W         = 8,
   parameter int          SYNC_STAGES  = 2,
   parameter bit          INT_CODE_EN  = 1'b1,
   parameter int unsigned INT_CODE_TOP = 32'h2000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [AD_W-1:0]          bus_ad_i,
   input  logic [HI_W-1:0]          bus_hi_i,
   input  logic                     ale_i,
   input  logic                     rd_n_i,
   input  logic                     wr_n_i,
   input  logic                     psen_n_i,
   input  logic [AD_W-1:0]          rdata_i,
   output logic [AD_W+2*HI_W-1:0]   data_addr_o,
   output logic [AD_W+HI_W-1:0]     prog_addr_o,
   output logic [1:0]               cyc_type_o,
   output logic                     access_o,
   output logic                     proto_err_o,
   output logic [AD_W-1:0]          wdata_o,
   output logic                     wdata_vld_o,
   output logic [AD_W-1:0]          rdout_o,
   output logic                     rdout_oe_o
);
   localparam int DATA_AW = AD_W + 2*HI_W;
   localparam int PROG_AW = AD_W + HI_W;
   localparam int BUS_W   = 4 + AD_W + HI_W;
   localparam logic [BUS_W-1:0] BUS_IDLE = {1'b0, 3'b111, {(AD_W+HI_W){1'b0}}};

   // elaboration-time parameter checks
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mbd_demux: SYNC_STAGES must be at least 2");
      end
      if (AD_W < 1 || HI_W < 1) begin : g_bad_width
         $error("mbd_demux: AD_W and HI_W must be positive");
      end
      if (INT_CODE_EN && (INT_CODE_TOP >= (32'd1 << PROG_AW))) begin : g_bad_top
         $error("mbd_demux: INT_CODE_TOP exceeds program space");
      end
   endgenerate

   logic [BUS_W-1:0] bus_s;
   logic             ale_s, rd_n_s, wr_n_s, psen_n_s;
   logic [AD_W-1:0]  ad_s;
   logic [HI_W-1:0]  hi_s;

   mbd_sync #(
      .W       (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ale_i, rd_n_i, wr_n_i, psen_n_i, bus_ad_i, bus_hi_i}),
      .q_o   (bus_s)
   );

   assign {ale_s, rd_n_s, wr_n_s, psen_n_s, ad_s, hi_s} = bus_s;

   logic [AD_W-1:0] lat_lo, ad_q;
   logic [HI_W-1:0] lat_hi, hi_q;

   mbd_addr_latch #(
      .AD_W (AD_W),
      .HI_W (HI_W)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ale_s    (ale_s),
      .ad_s     (ad_s),
      .hi_s     (hi_s),
      .lat_lo_o (lat_lo),
      .lat_hi_o (lat_hi),
      .hi_q_o   (hi_q),
      .ad_q_o   (ad_q)
   );

   // Upper port: latched part above live part above latched low byte.
   assign data_addr_o = DATA_AW'({lat_hi, hi_q, lat_lo});
   assign prog_addr_o = PROG_AW'({hi_q, lat_lo});

   cyc_e cyc;
   logic rd_only_s;

   mbd_cycle_decode #(
      .AD_W         (AD_W),
      .PROG_AW      (PROG_AW),
      .INT_CODE_EN  (INT_CODE_EN),
      .INT_CODE_TOP (INT_CODE_TOP)
   ) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .psen_n_s    (psen_n_s),
      .rd_n_s      (rd_n_s),
      .wr_n_s      (wr_n_s),
      .ad_q        (ad_q),
      .prog_addr_i (prog_addr_o),
      .cyc_o       (cyc),
      .access_o    (access_o),
      .err_o       (proto_err_o),
      .wdata_o     (wdata_o),
      .wvld_o      (wdata_vld_o),
      .rd_only_o   (rd_only_s)
   );

   assign cyc_type_o = cyc;

   mbd_read_port #(
      .AD_W (AD_W)
   ) u_rport (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_only_s (rd_only_s),
      .rdata_i   (rdata_i),
      .rdout_o   (rdout_o),
      .oe_o      (rdout_oe_o)
   );
endmodule

// File: rtl/mbd_demux_chk.sv
module mbd_demux_chk #(
   parameter int          AD_W         = 8,
   parameter int          HI_W         = 8,
   parameter bit          INT_CODE_EN  = 1'b1,
   parameter int unsigned INT_CODE_TOP = 32'h2000
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   ale_i,
   input logic                   rd_n_i,
   input logic                   wr_n_i,
   input logic                   psen_n_i,
   input logic [AD_W+2*HI_W-1:0] data_addr_o,
   input logic [AD_W+HI_W-1:0]   prog_addr_o,
   input logic [1:0]             cyc_type_o,
   input logic                   access_o,
   input logic                   proto_err_o,
   input logic                   wdata_vld_o,
   input logic                   rdout_oe_o
);
   localparam int DATA_AW = AD_W + 2*HI_W;
   localparam int PROG_AW = AD_W + HI_W;
   localparam logic [PROG_AW-1:0] TOP_L = PROG_AW'(INT_CODE_TOP);

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o); // R7

   AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ale_i, 3) |-> $stable(data_addr_o[AD_W-1:0])); // R2

   AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ale_i, 3) |-> $stable(data_addr_o[DATA_AW-1:DATA_AW-HI_W])); // R2

   AST_WRITE_SOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type_o == 2'd3) |-> $past(!wr_n_i && rd_n_i && psen_n_i, 3)); // R5

   AST_READ_OE_SOLE: assert property (@(posedge clk) disable iff (!rst_n)
      rdout_oe_o |-> $past(!rd_n_i && wr_n_i && psen_n_i, 3)); // R9

   AST_WVLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_vld_o |=> !wdata_vld_o); // R8

   AST_INTERNAL_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (INT_CODE_EN && cyc_type_o == 2'd1 && prog_addr_o < TOP_L) |-> !access_o); // R6
endmodule

bind mbd_demux mbd_demux_chk #(
   .AD_W         (AD_W),
   .HI_W         (HI_W),
   .INT_CODE_EN  (INT_CODE_EN),
   .INT_CODE_TOP (INT_CODE_TOP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ale_i       (ale_i),
   .rd_n_i      (rd_n_i),
   .wr_n_i      (wr_n_i),
   .psen_n_i    (psen_n_i),
   .data_addr_o (data_addr_o),
   .prog_addr_o (prog_addr_o),
   .cyc_type_o  (cyc_type_o),
   .access_o    (access_o),
   .proto_err_o (proto_err_o),
   .wdata_vld_o (wdata_vld_o),
   .rdout_oe_o  (rdout_oe_o)
);

// File: tb/mbd_demux_tb.sv
module mbd_demux_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_ad_i = '0, bus_hi_i = '0, rdata_i = '0;
   logic        ale_i = 1'b0, rd_n_i = 1'b1, wr_n_i = 1'b1, psen_n_i = 1'b1;
   logic [23:0] data_addr_o;
   logic [15:0] prog_addr_o;
   logic [1:0]  cyc_type_o;
   logic        access_o, proto_err_o, wdata_vld_o, rdout_oe_o;
   logic [7:0]  wdata_o, rdout_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk; // 50 MHz

   mbd_demux u_dut (
      .clk(clk), .rst_n(rst_n), .bus_ad_i(bus_ad_i), .bus_hi_i(bus_hi_i),
      .ale_i(ale_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .psen_n_i(psen_n_i),
      .rdata_i(rdata_i), .data_addr_o(data_addr_o), .prog_addr_o(prog_addr_o),
      .cyc_type_o(cyc_type_o), .access_o(access_o), .proto_err_o(proto_err_o),
      .wdata_o(wdata_o), .wdata_vld_o(wdata_vld_o), .rdout_o(rdout_o),
      .rdout_oe_o(rdout_oe_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   // sample word: [19] ale, [18] rd_n, [17] wr_n, [16] psen_n, [15:8] ad, [7:0] hi
   localparam logic [19:0] IDLE = {1'b0, 3'b111, 16'h0};
   logic [19:0] hq[$];
   logic [7:0]  m_lo, m_hh, m_mid, m_wd, m_rd;
   logic [1:0]  m_type;
   logic        m_acc, m_err, m_wv, m_oe;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hq = {IDLE, IDLE, IDLE, IDLE};
         m_lo = 0; m_hh = 0; m_mid = 0; m_wd = 0; m_rd = 0;
         m_type = 0; m_acc = 0; m_err = 0; m_wv = 0; m_oe = 0;
      end else begin
         logic [19:0] h2, h3;
         logic [2:0]  lows;
         int          n;
         hq.push_front({ale_i, rd_n_i, wr_n_i, psen_n_i, bus_ad_i, bus_hi_i});
         if (hq.size() > 4) void'(hq.pop_back());
         h2 = hq[2];
         h3 = hq[3];
         if (h2[19]) begin
            m_lo = h2[15:8];
            m_hh = h2[7:0];
         end
         m_mid = h2[7:0];
         lows = {~h2[16], ~h2[18], ~h2[17]};
         n = int'(lows[0]) + int'(lows[1]) + int'(lows[2]);
         if (n == 1) m_type = lows[2] ? 2'd1 : (lows[1] ? 2'd2 : 2'd3);
         else        m_type = 2'd0;
         if (n > 1) m_err = 1'b1;
         m_wv = !h3[17] && h2[17];
         if (m_wv) m_wd = h3[15:8];
         m_oe = (lows == 3'b010);
         if (m_oe) m_rd = rdata_i;
         m_acc = (m_type != 0) && !((m_type == 2'd1) && ({m_mid, m_lo} < 16'h2000));
      end
   end

   // compare every clock, a quarter period after the rising edge
   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         chk("R2", "data_addr[7:0]",   data_addr_o[7:0],   m_lo);
         chk("R2", "data_addr[23:16]", data_addr_o[23:16], m_hh);
         chk("R3", "data_addr[15:8]",  data_addr_o[15:8],  m_mid);
         chk("R4", "prog_addr",        prog_addr_o,        {m_mid, m_lo});
         chk("R5", "cyc_type",         cyc_type_o,         m_type);
         chk("R6", "access",           access_o,           m_acc);
         chk("R7", "proto_err",        proto_err_o,        m_err);
         chk("R8", "wdata_vld",        wdata_vld_o,        m_wv);
         chk("R8", "wdata",            wdata_o,            m_wd);
         chk("R9", "rdout_oe",         rdout_oe_o,         m_oe);
         chk("R9", "rdout",            rdout_o,            m_rd);
      end
   end

   // ---------------- stimulus ----------------
   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic data_cycle(input logic [23:0] a, input logic is_wr, input logic [7:0] d);
      @(negedge clk); ale_i = 1'b1; bus_ad_i = a[7:0]; bus_hi_i = a[23:16];
      wait_clk(3);    ale_i = 1'b0;
      wait_clk(2);    bus_hi_i = a[15:8]; bus_ad_i = is_wr ? d : 8'hEE;
                      rdata_i = a[7:0] ^ 8'h5C;
      if (is_wr) wr_n_i = 1'b0; else rd_n_i = 1'b0;
      wait_clk(4);    wr_n_i = 1'b1; rd_n_i = 1'b1;
      wait_clk(2);    bus_ad_i = '0; bus_hi_i = '0;
      wait_clk(2);
   endtask

   task automatic fetch(input logic [15:0] a);
      @(negedge clk); ale_i = 1'b1; bus_ad_i = a[7:0]; bus_hi_i = a[15:8];
      wait_clk(3);    ale_i = 1'b0;
      wait_clk(2);    bus_ad_i = 8'h5A; psen_n_i = 1'b0;
      wait_clk(4);    psen_n_i = 1'b1;
      wait_clk(2);    bus_ad_i = '0; bus_hi_i = '0;
      wait_clk(2);
   endtask

   task automatic reset_check();
      // R1: outputs during reset
      chk("R1", "reset data_addr", data_addr_o, 0);
      chk("R1", "reset prog_addr", prog_addr_o, 0);
      chk("R1", "reset cyc_type",  cyc_type_o,  0);
      chk("R1", "reset access",    access_o,    0);
      chk("R1", "reset proto_err", proto_err_o, 0);
      chk("R1", "reset wdata",     {wdata_vld_o, wdata_o}, 0);
      chk("R1", "reset rdout",     {rdout_oe_o, rdout_o}, 0);
   endtask

   task automatic run_all();
      wait_clk(5);
      reset_check();
      rst_n = 1'b1;
      wait_clk(4);
      fetch(16'h1FFF);   // R6 internal
      fetch(16'h2000);   // R6 external boundary
      fetch(16'h0000);
      fetch(16'hFFFF);
      data_cycle(24'h123456, 1'b1, 8'hA5);
      data_cycle(24'hFFFFFF, 1'b0, 8'h00);
      data_cycle(24'h000000, 1'b1, 8'h3C);
      data_cycle(24'hABCDEF, 1'b0, 8'h00);
      data_cycle(24'h80FF01, 1'b1, 8'hFF);
      // R7: overlapping read and write strobes
      @(negedge clk); rd_n_i = 1'b0; wr_n_i = 1'b0;
      wait_clk(3);    rd_n_i = 1'b1; wr_n_i = 1'b1;
      wait_clk(4);
      chk("R7", "error after overlap", proto_err_o, 1);
      data_cycle(24'h0102FE, 1'b0, 8'h00);
      chk("R7", "error still set", proto_err_o, 1);
      // R1: reset clears the sticky flag
      @(negedge clk); rst_n = 1'b0;
      wait_clk(2);
      reset_check();
      rst_n = 1'b1;
      wait_clk(3);
      fetch(16'h2001);
      data_cycle(24'h7E8001, 1'b1, 8'h81);
      wait_clk(10);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule